// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses the direction of a conditional branch. Two component predictors run side by side. The first is a global predictor: it XORs the branch address with a shift register holding recent branch outcomes, and uses the result to select a saturating counter. The second is a local predictor with two levels. A per-branch history table is read by address. That history is XORed with the address, and the result selects a second counter table. A chooser table, indexed by the address alone, decides per branch which component to trust.

A lookup is purely combinational. The fetch stage presents the low-order PC bits and gets the final direction in the same cycle. It also gets both component guesses and the chooser's pick. When the branch resolves, the execution side presents the PC and the real outcome, together with the two component guesses it kept from lookup.

On that update the component counters are trained and the chooser is adjusted. Both histories then shift in the outcome. No history moves speculatively at lookup. Every table size and counter width is a parameter.

Top module: `tournament_bp`

## Requirements
- R1: After reset every global counter holds the weakly-not-taken value 3 (3-bit counters). Every local counter and every chooser counter holds 1 (2-bit counters). All histories are zero. So every lookup reports all four outputs as 0.
- R2: A counter predicts taken exactly when its most significant bit is 1.
- R3: A counter trained taken at its maximum value stays at the maximum and does not wrap.
- R4: A counter trained not-taken at zero stays at zero and does not wrap.
- R5: The global counter index is the low GHW PC bits XORed with the GHW-bit global history.
- R6: The local history entry is selected by the low L1W PC bits. The local counter index is the low LHW PC bits XORed with that entry.
- R7: The chooser is indexed by the low SELW PC bits. A value of 2 or more (MSB set) makes lk_taken follow the global guess; otherwise it follows the local guess.
- R8: On update the chooser counts up when only the global guess was right and down when only the local guess was right. Otherwise it holds.
- R9: Every update trains both the addressed global counter and the addressed local counter toward the outcome, whichever component was chosen.
- R10: After training, the outcome shifts into bit 0 of the global history and of the addressed local history entry. Without an update neither history changes.
- R11: A cycle with up_valid low changes no state. A lookup in the same cycle as an update sees the state from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PCW | Low PC bits of the branch being looked up |
| lk_taken | output | 1 | Final predicted direction |
| lk_glob_taken | output | 1 | Global component guess |
| lk_local_taken | output | 1 | Local component guess |
| lk_pick_global | output | 1 | Chooser selects the global component |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | PCW | Low PC bits of the resolved branch |
| up_taken | input | 1 | Actual outcome |
| up_glob_taken | input | 1 | Global guess captured at lookup |
| up_local_taken | input | 1 | Local guess captured at lookup |

## Verification
A corrupted counter or history entry stays hidden until a lookup lands on the affected index. Because of that, the bench keeps a behavioural model of the three tables and both histories. It compares all four lookup outputs before every update.

A wrong global history shifts every global index for the next update's lookup, so it shows at once. A wrong local history shows only on the branch that owns the entry. A chooser fault can take two or more updates to cross the taken threshold and appear on lk_taken. For that reason the bench also runs long same-direction runs and directed chooser sequences.

// File: rtl/tournament_bp.sv
module tournament_bp #(
  parameter int SELW = 12,
  parameter int GHW  = 12,
  parameter int GCW  = 3,
  parameter int L1W  = 8,
  parameter int LHW  = 12,
  parameter int LCW  = 2,
  parameter int SCW  = 2,
  localparam int PCW = (SELW > GHW ? (SELW > LHW ? SELW : LHW) : (GHW > LHW ? GHW : LHW)) > L1W ?
                       (SELW > GHW ? (SELW > LHW ? SELW : LHW) : (GHW > LHW ? GHW : LHW)) : L1W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [PCW-1:0] lk_pc,
  output logic           lk_taken,
  output logic           lk_glob_taken,
  output logic           lk_local_taken,
  output logic           lk_pick_global,
  input  logic           up_valid,
  input  logic [PCW-1:0] up_pc,
  input  logic           up_taken,
  input  logic           up_glob_taken,
  input  logic           up_local_taken
);
  localparam int SDEPTH = 1 << SELW;
  localparam int GDEPTH = 1 << GHW;
  localparam int HDEPTH = 1 << L1W;
  localparam int LDEPTH = 1 << LHW;
  localparam logic [GCW-1:0] G_MAX  = '1;
  localparam logic [LCW-1:0] L_MAX  = '1;
  localparam logic [SCW-1:0] S_MAX  = '1;
  localparam logic [GCW-1:0] G_WEAK = {1'b0, {(GCW-1){1'b1}}};
  localparam logic [LCW-1:0] L_WEAK = {1'b0, {(LCW-1){1'b1}}};
  localparam logic [SCW-1:0] S_WEAK = {1'b0, {(SCW-1){1'b1}}};

  logic [SCW-1:0] sel_tab [SDEPTH];
  logic [GCW-1:0] glb_tab [GDEPTH];
  logic [LHW-1:0] lhist   [HDEPTH];
  logic [LCW-1:0] loc_tab [LDEPTH];
  logic [GHW-1:0] ghist;

  // lookup side
  logic [SELW-1:0] l_sel;
  logic [GHW-1:0]  l_glb;
  logic [L1W-1:0]  l_hst;
  logic [LHW-1:0]  l_loc;
  assign l_sel = lk_pc[SELW-1:0];
  assign l_glb = lk_pc[GHW-1:0] ^ ghist;
  assign l_hst = lk_pc[L1W-1:0];
  assign l_loc = lk_pc[LHW-1:0] ^ lhist[l_hst];

  assign lk_glob_taken  = glb_tab[l_glb][GCW-1];
  assign lk_local_taken = loc_tab[l_loc][LCW-1];
  assign lk_pick_global = sel_tab[l_sel][SCW-1];
  assign lk_taken       = lk_pick_global ? lk_glob_taken : lk_local_taken;

  // update side
  logic [SELW-1:0] u_sel;
  logic [GHW-1:0]  u_glb;
  logic [L1W-1:0]  u_hst;
  logic [LHW-1:0]  u_loc;
  logic [SCW-1:0]  s_cur, s_nxt;
  logic [GCW-1:0]  g_cur, g_nxt;
  logic [LCW-1:0]  c_cur, c_nxt;
  logic            g_ok, c_ok;

  assign u_sel = up_pc[SELW-1:0];
  assign u_glb = up_pc[GHW-1:0] ^ ghist;
  assign u_hst = up_pc[L1W-1:0];
  assign u_loc = up_pc[LHW-1:0] ^ lhist[u_hst];
  assign s_cur = sel_tab[u_sel];
  assign g_cur = glb_tab[u_glb];
  assign c_cur = loc_tab[u_loc];
  assign g_ok  = (up_glob_taken == up_taken);
  assign c_ok  = (up_local_taken == up_taken);

  assign g_nxt = up_taken ? ((g_cur == G_MAX) ? g_cur : g_cur + 1'b1)
                          : ((g_cur == '0)    ? g_cur : g_cur - 1'b1);
  assign c_nxt = up_taken ? ((c_cur == L_MAX) ? c_cur : c_cur + 1'b1)
                          : ((c_cur == '0)    ? c_cur : c_cur - 1'b1);
  assign s_nxt = (g_ok && !c_ok && s_cur != S_MAX) ? s_cur + 1'b1 :
                 (!g_ok && c_ok && s_cur != '0)    ? s_cur - 1'b1 : s_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SDEPTH; i++) sel_tab[i] <= S_WEAK;
      for (int i = 0; i < GDEPTH; i++) glb_tab[i] <= G_WEAK;
      for (int i = 0; i < LDEPTH; i++) loc_tab[i] <= L_WEAK;
      for (int i = 0; i < HDEPTH; i++) lhist[i]   <= '0;
      ghist <= '0;
    end else if (up_valid) begin
      sel_tab[u_sel] <= s_nxt;
      glb_tab[u_glb] <= g_nxt;
      loc_tab[u_loc] <= c_nxt;
      lhist[u_hst]   <= {lhist[u_hst][LHW-2:0], up_taken};
      ghist          <= {ghist[GHW-2:0], up_taken};
    end
  end

  assert_reset_weak_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !lk_taken && !lk_glob_taken && !lk_local_taken && !lk_pick_global);

  assert_gsat_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_taken && g_cur == G_MAX) |=> glb_tab[$past(u_glb)] == G_MAX);

  assert_lsat_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_taken && c_cur == '0) |=> loc_tab[$past(u_loc)] == '0);

  assert_sel_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && (g_ok == c_ok)) |=> sel_tab[$past(u_sel)] == $past(s_cur));

  assert_ghist_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> ghist[0] == $past(up_taken));

  assert_ghist_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(ghist));
endmodule

// File: tb/test_tournament_bp.sv
module test_tournament_bp;
  localparam int SELW = 4, GHW = 4, L1W = 2, LHW = 4;
  localparam int N = 24;
  // each vector: {pc[3:0], outcome}
  localparam logic [4:0] VEC [N] = '{
    5'b0011_1, 5'b0011_1, 5'b0011_1, 5'b0011_0, 5'b0101_1, 5'b0011_1,
    5'b0011_1, 5'b0011_1, 5'b0011_0, 5'b0101_1, 5'b1010_0, 5'b0011_1,
    5'b0011_1, 5'b0011_1, 5'b0011_0, 5'b0101_1, 5'b1010_0, 5'b0110_1,
    5'b0011_1, 5'b0011_1, 5'b0011_1, 5'b0011_0, 5'b0101_1, 5'b1110_1};

  logic clk = 0, rst_n = 0;
  logic [3:0] lk_pc = '0, up_pc = '0;
  logic lk_taken, lk_glob_taken, lk_local_taken, lk_pick_global;
  logic up_valid = 0, up_taken = 0, up_glob_taken = 0, up_local_taken = 0;
  int checks = 0, failures = 0;
  bit done = 0;

  int sel_m [16];
  int g_m   [16];
  int l2_m  [16];
  logic [3:0] l1_m [4];
  logic [3:0] gh_m;

  always #10 clk = ~clk;

  tournament_bp #(.SELW(SELW), .GHW(GHW), .L1W(L1W), .LHW(LHW)) i_tournament_bp (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .lk_glob_taken(lk_glob_taken), .lk_local_taken(lk_local_taken),
    .lk_pick_global(lk_pick_global), .up_valid(up_valid), .up_pc(up_pc),
    .up_taken(up_taken), .up_glob_taken(up_glob_taken), .up_local_taken(up_local_taken));

  function automatic logic m_glob(logic [3:0] pc);
    return g_m[pc ^ gh_m] >= 4;
  endfunction
  function automatic logic m_loc(logic [3:0] pc);
    return l2_m[pc ^ l1_m[pc[1:0]]] >= 2;
  endfunction
  function automatic logic m_pick(logic [3:0] pc);
    return sel_m[pc] >= 2;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin sel_m[i] = 1; g_m[i] = 3; l2_m[i] = 1; end
    for (int i = 0; i < 4; i++) l1_m[i] = '0;
    gh_m = '0;
  endtask

  task automatic model_update(logic [3:0] pc, logic t, logic gp, logic lp);
    int gi, li;
    gi = pc ^ gh_m;
    li = pc ^ l1_m[pc[1:0]];
    if (t) begin
      if (g_m[gi] < 7) g_m[gi]++;
      if (l2_m[li] < 3) l2_m[li]++;
    end else begin
      if (g_m[gi] > 0) g_m[gi]--;
      if (l2_m[li] > 0) l2_m[li]--;
    end
    if (gp == t && lp != t && sel_m[pc] < 3) sel_m[pc]++;
    else if (gp != t && lp == t && sel_m[pc] > 0) sel_m[pc]--;
    gh_m = {gh_m[2:0], t};
    l1_m[pc[1:0]] = {l1_m[pc[1:0]][2:0], t};
  endtask

  task automatic chk(logic act, logic exp, string tag, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic check_lookup(logic [3:0] pc, string tag);
    logic g, l, p;
    @(negedge clk);
    lk_pc = pc;
    #2;
    g = m_glob(pc); l = m_loc(pc); p = m_pick(pc);
    chk(lk_glob_taken,  g, tag, "global guess (R2 R5)");
    chk(lk_local_taken, l, tag, "local guess (R2 R6)");
    chk(lk_pick_global, p, tag, "chooser pick (R7)");
    chk(lk_taken, p ? g : l, tag, "final direction (R7)");
  endtask

  task automatic do_update(logic [3:0] pc, logic t, logic gp, logic lp);
    @(negedge clk);
    up_valid = 1; up_pc = pc; up_taken = t; up_glob_taken = gp; up_local_taken = lp;
    @(posedge clk);
    #1 up_valid = 0;
    model_update(pc, t, gp, lp);
  endtask

  task automatic step(logic [3:0] pc, logic t, string tag);
    check_lookup(pc, tag);
    do_update(pc, t, m_glob(pc), m_loc(pc));
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    // R1: every lookup after reset reports not-taken
    for (int p = 0; p < 16; p++) check_lookup(4'(p), "R1");

    // R5 R6 R7 R9 R10: mixed branch patterns
    for (int v = 0; v < N; v++) step(VEC[v][4:1], VEC[v][0], "R9 R10 vector");

    // R11: idle cycles with garbage on the update side change nothing
    @(negedge clk);
    up_pc = 4'hA; up_taken = 1; up_glob_taken = 0; up_local_taken = 1;
    repeat (4) @(negedge clk);
    for (int p = 0; p < 16; p++) check_lookup(4'(p), "R11");

    // R11: lookup in the update cycle sees pre-update state
    @(negedge clk);
    lk_pc = 4'h3; up_valid = 1; up_pc = 4'h3; up_taken = ~m_glob(4'h3);
    up_glob_taken = m_glob(4'h3); up_local_taken = m_loc(4'h3);
    #2;
    chk(lk_glob_taken, m_glob(4'h3), "R11", "same-cycle lookup");
    @(posedge clk);
    #1 up_valid = 0;
    model_update(4'h3, up_taken, up_glob_taken, up_local_taken);
    check_lookup(4'h3, "R11 after");

    // R3: long taken run saturates at maximum
    do_reset();
    for (int i = 0; i < 14; i++) step(4'h0, 1'b1, "R3");
    step(4'h0, 1'b0, "R3");
    step(4'h0, 1'b1, "R3");

    // R4: long not-taken run saturates at zero
    do_reset();
    for (int i = 0; i < 14; i++) step(4'h0, 1'b0, "R4");
    step(4'h0, 1'b1, "R4");
    step(4'h0, 1'b0, "R4");

    // R8: chooser moves only when exactly one component was right
    do_reset();
    do_update(4'h3, 1, 1, 0); check_lookup(4'h3, "R8 up");
    do_update(4'h3, 1, 1, 0); check_lookup(4'h3, "R8 up");
    do_update(4'h3, 1, 1, 0); check_lookup(4'h3, "R8 sat");
    do_update(4'h3, 1, 1, 1); check_lookup(4'h3, "R8 both right");
    do_update(4'h3, 0, 1, 1); check_lookup(4'h3, "R8 both wrong");
    do_update(4'h3, 0, 1, 0); check_lookup(4'h3, "R8 down");
    do_update(4'h3, 0, 1, 0); check_lookup(4'h3, "R8 down");
    do_update(4'h3, 0, 1, 0); check_lookup(4'h3, "R8 down");
    do_update(4'h3, 0, 1, 0); check_lookup(4'h3, "R8 floor");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule